// File: doc/BRIEF.md
# Edge-Timed Pulse Duration Capture

This block measures a demodulated one-bit receive signal as a stream of alternating high and low durations. It uses one tick counter that runs off a prescaled time base. Each accepted rising edge of the signal restarts the counter from zero. When the signal falls, the counter value is the length of the high pulse. It is reported and also kept. When the signal next rises, the counter value at that moment, less the kept value, is the length of the low pulse that just ended. Each result leaves the block as a one-cycle valid pulse, a level bit and a duration in ticks.

The input first passes through a two-flop synchronizer. Falling edges are taken from the synchronized signal directly. Rising edges are taken only after a sampled glitch filter confirms them, so short spikes cannot restart the measurement. An enable input starts and stops capture. A mirror output rebuilds the signal from the two kinds of event, and can drive a monitoring pin. With default parameters and a 64 MHz clock, one tick is 1 µs, and the filter samples every 32 clocks and needs 8 matching samples.

Top module: `pulse_width_capture`

## Requirements
- R1: The counter advances by one once every TICK_DIV clocks. Its tick phase restarts at zero together with the count, so every reported duration equals floor(clock edges elapsed / TICK_DIV).
- R2: A high-to-low change of the synchronized input produces a report with out_level = 1. Its out_dur is the number of ticks since the last accepted rising event, or since capture was enabled. This value is also stored as the falling capture.
- R3: An accepted rising event produces a report with out_level = 0. Its out_dur is (counter value at that edge − stored falling capture) modulo 2^CNT_W. The same event restarts the counter and the tick phase at zero.
- R4: On a tick, the counter goes from CNT_MAX back to 0, so captured values run modulo CNT_MAX+1.
- R5: A rising event is accepted only after FILT_LEN consecutive filter samples of the new level, with one sample taken every FILT_DIV clocks. A shorter high pulse produces no low report but still produces a high report when it ends. A low spike shorter than FILT_LEN samples still produces a high report, but the rise that follows it is not reported.
- R6: The mirror output goes to 0 on each high report and to 1 on each accepted rising event.
- R7: While en is 0, no report is made, mirror is 0, the counter is held at 0 and the stored falling capture is 0. Counting after en rises starts from zero.
- R8: If a falling event and an accepted rising event land on the same edge, the high report is made first. The low report, with duration 0, follows on the next cycle, and mirror ends at 1.
- R9: During reset, out_valid, out_level, out_dur and mirror are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Capture enable (start/stop) |
| sig_in | input | 1 | Asynchronous demodulated receive signal |
| out_valid | output | 1 | One-cycle strobe for a finished measurement |
| out_level | output | 1 | 1 = high-pulse duration, 0 = low-pulse duration |
| out_dur | output | CNT_W | Measured duration in ticks |
| mirror | output | 1 | Signal level rebuilt from the capture events |

## Verification
The bench drives sig_in right after a falling clock edge. Call the rising edge just before that change edge a. A high report appears after edge a+3: two synchronizer stages plus the edge-detect register. An accepted rise is reported after edge a+3+FILT_LEN when the filter takes a sample every clock. For each segment it drives, the bench works out the report cycle, the level, the duration and the mirror value, and queues them in order. In the tie case the low report moves to the following cycle. At each falling clock edge, the bench compares out_valid against the head of the queue. A report that comes early, late, missing or unexpected fails its requirement.

// File: rtl/pwc_pkg.sv
// Package: shared helpers for the pulse duration capture block.
// Assumes only constant-expression use of its functions.
package pwc_pkg;

    // Register width needed to hold values 0..v-1, at least one bit.
    function automatic int width_of(input int v);
        return (v <= 2) ? 1 : $clog2(v);
    endfunction

endpackage

// File: rtl/pwc_divider.sv
// Module: clock-enable divider. Raises tick once every DIV clocks.
// The phase returns to zero while clr is high, so the first tick after clr
// comes DIV edges later. DIV of 1 gives a tick on every clock.
module pwc_divider #(
    parameter int DIV = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_pass
            logic unused_div;
            assign unused_div = clk ^ rst_n ^ clr;
            assign tick = 1'b1;
        end else begin : g_cnt
            localparam int PW = pwc_pkg::width_of(DIV);
            localparam logic [PW-1:0] PHASE_LAST = PW'(DIV - 1);
            logic [PW-1:0] phase;

            assign tick = (phase == PHASE_LAST);

            // Phase counter: cleared by reset or clr, wraps on each tick.
            always_ff @(posedge clk) begin
                if (!rst_n || clr) begin
                    phase <= '0;
                end else begin
                    phase <= tick ? '0 : phase + 1'b1;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/pwc_sync.sv
// Module: two-flop synchronizer for the asynchronous receive input.
// Assumes the input is a slow level signal. The output lags by two edges.
module pwc_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [1:0] stages;

    // Shift the raw input through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stages <= 2'b00;
        end else begin
            stages <= {stages[0], din};
        end
    end

    assign dout = stages[1];
endmodule

// File: rtl/pwc_glitch_filter.sv
// Module: sampled majority-free glitch filter for the rising-edge path.
// Takes a sample every FILT_DIV clocks. The filtered level changes only after
// FILT_LEN consecutive samples of the opposite value. Held at 0 while not running.
module pwc_glitch_filter #(
    parameter int FILT_DIV = 32,
    parameter int FILT_LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic din,
    output logic lvl
);
    localparam int CW = pwc_pkg::width_of(FILT_LEN);
    localparam logic [CW-1:0] RUN_LAST = CW'(FILT_LEN - 1);

    logic          samp;
    logic [CW-1:0] run_len;

    pwc_divider #(.DIV(FILT_DIV)) samp_div_i (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (!run),
        .tick (samp)
    );

    // Count matching samples of the opposite level and flip once enough are seen.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            lvl     <= 1'b0;
            run_len <= '0;
        end else if (samp) begin
            if (din != lvl) begin
                if (run_len == RUN_LAST) begin
                    lvl     <= din;
                    run_len <= '0;
                end else begin
                    run_len <= run_len + 1'b1;
                end
            end else begin
                run_len <= '0;
            end
        end
    end
endmodule

// File: rtl/pwc_tick_counter.sv
// Module: prescaled tick counter with restart and wrap.
// cap_val is the value the count takes at this edge, including a tick that
// happens now. That makes a capture equal to the ticks elapsed through this edge.
// Held at zero while not running. restart clears both count and tick phase.
module pwc_tick_counter #(
    parameter int          CNT_W    = 31,
    parameter longint unsigned CNT_MAX = 64'h7FFF_FFFE,
    parameter int          TICK_DIV = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    output logic [CNT_W-1:0] cap_val
);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CNT_MAX);

    logic             tick;
    logic [CNT_W-1:0] count;

    pwc_divider #(.DIV(TICK_DIV)) tick_div_i (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (!run || restart),
        .tick (tick)
    );

    // Next count value: advance on a tick, wrap after the last value.
    always_comb begin
        if (tick) begin
            cap_val = (count == CNT_LAST) ? '0 : count + 1'b1;
        end else begin
            cap_val = count;
        end
    end

    // Count register: cleared when idle or on restart, otherwise advances.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || restart) begin
            count <= '0;
        end else begin
            count <= cap_val;
        end
    end
endmodule

// File: rtl/pulse_width_capture.sv
// Module: top of the pulse duration capture block.
// Falling events come from the synchronized signal. Rising events come from
// the glitch filter. One counter, restarted by rising events, gives both
// durations. The low duration is rise capture minus stored fall capture.
// Assumes sig_in is asynchronous and en is synchronous to clk.
module pulse_width_capture #(
    parameter int              CNT_W    = 31,
    parameter longint unsigned CNT_MAX  = 64'h7FFF_FFFE,
    parameter int              TICK_DIV = 64,
    parameter int              FILT_DIV = 32,
    parameter int              FILT_LEN = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             sig_in,
    output logic             out_valid,
    output logic             out_level,
    output logic [CNT_W-1:0] out_dur,
    output logic             mirror
);
    logic             sig_s;
    logic             sig_q;
    logic             filt_lvl;
    logic             filt_q;
    logic             fall_ev;
    logic             rise_ev;
    logic             tie_pend;
    logic [CNT_W-1:0] cap_now;
    logic [CNT_W-1:0] fall_cap;

    pwc_sync sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (sig_in),
        .dout (sig_s)
    );

    pwc_glitch_filter #(.FILT_DIV(FILT_DIV), .FILT_LEN(FILT_LEN)) filt_i (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (en),
        .din  (sig_s),
        .lvl  (filt_lvl)
    );

    pwc_tick_counter #(.CNT_W(CNT_W), .CNT_MAX(CNT_MAX), .TICK_DIV(TICK_DIV)) cnt_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (en),
        .restart(rise_ev),
        .cap_val(cap_now)
    );

    // Delayed copies for edge detection on both paths.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sig_q  <= 1'b0;
            filt_q <= 1'b0;
        end else begin
            sig_q  <= sig_s;
            filt_q <= en ? filt_lvl : 1'b0;
        end
    end

    assign fall_ev = en && sig_q && !sig_s;
    assign rise_ev = en && filt_lvl && !filt_q;

    // Report sequencing: fall first, a tied rise waits one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            out_valid <= 1'b0;
            out_level <= 1'b0;
            out_dur   <= '0;
            mirror    <= 1'b0;
            fall_cap  <= '0;
            tie_pend  <= 1'b0;
        end else begin
            out_valid <= fall_ev || tie_pend || rise_ev;
            if (fall_ev) begin
                out_level <= 1'b1;
                out_dur   <= cap_now;
                fall_cap  <= cap_now;
                mirror    <= rise_ev;
                tie_pend  <= rise_ev;
            end else if (tie_pend) begin
                out_level <= 1'b0;
                out_dur   <= '0;
                tie_pend  <= 1'b0;
            end else if (rise_ev) begin
                out_level <= 1'b0;
                out_dur   <= cap_now - fall_cap;
                mirror    <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/pwc_checker.sv
// Module: property checker for pulse_width_capture, attached by bind.
// Watches only the top-level ports.
module pwc_checker #(
    parameter int CNT_W = 31
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             out_valid,
    input logic             out_level,
    input logic [CNT_W-1:0] out_dur,
    input logic             mirror
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !mirror && out_dur == '0)); // R9

    AST_IDLE_NO_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !out_valid); // R7

    AST_IDLE_MIRROR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !mirror); // R7

    AST_LOW_REPORT_MIRROR_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_level) |-> mirror); // R6

    AST_MIRROR_FALLS_ON_HIGH_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mirror) && $past(en)) |-> (out_valid && out_level)); // R6

    AST_NO_ADJACENT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_level) |=> !(out_valid && !out_level)); // R5

    AST_TIE_ORDER: assert property (@(posedge clk) disable iff (!rst_n || !en)
        (out_valid && out_level && mirror) |=> (out_valid && !out_level && out_dur == '0)); // R8
endmodule

bind pulse_width_capture pwc_checker #(.CNT_W(CNT_W)) pwc_checker_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .out_valid(out_valid),
    .out_level(out_level),
    .out_dur  (out_dur),
    .mirror   (mirror)
);

// File: tb/pulse_width_capture_tb_top.sv
`timescale 1ns/1ps
module pulse_width_capture_tb_top;
    localparam int TDIV = 4;
    localparam int FDIV = 1;
    localparam int FLEN = 4;
    localparam int W    = 8;
    localparam int MAXV = 254;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en = 1'b0;
    logic         sig_in = 1'b0;
    logic         out_valid;
    logic         out_level;
    logic [W-1:0] out_dur;
    logic         mirror;

    pulse_width_capture #(
        .CNT_W(W), .CNT_MAX(64'(MAXV)), .TICK_DIV(TDIV), .FILT_DIV(FDIV), .FILT_LEN(FLEN)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .sig_in(sig_in),
        .out_valid(out_valid), .out_level(out_level), .out_dur(out_dur), .mirror(mirror)
    );

    always #2.5 clk = ~clk;

    int    cyc = 0;
    int    n_chk = 0;
    int    n_fail = 0;
    bit    started = 0;
    bit    done = 0;
    int    last_r = 0;
    int    fcap = 0;
    bit    filt_m = 0;
    string tag_hi = "R2";
    string tag_lo = "R3";
    string idle_req = "R5";

    int    q_cyc[$];
    int    q_lvl[$];
    int    q_dur[$];
    int    q_mir[$];
    string q_req[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int ticks(int e);
        return ((e - last_r) / TDIV) % (MAXV + 1);
    endfunction

    task automatic push(int c, int l, int d, int m, string req);
        q_cyc.push_back(c); q_lvl.push_back(l); q_dur.push_back(d);
        q_mir.push_back(m); q_req.push_back(req);
    endtask

    task automatic pop();
        void'(q_cyc.pop_front()); void'(q_lvl.pop_front()); void'(q_dur.pop_front());
        void'(q_mir.pop_front()); void'(q_req.pop_front());
    endtask

    // Expected reports for a high stretch: optional accepted rise at r, fall at f.
    task automatic expect_high(int r, bit acc, int f);
        int fc;
        int rc;
        if (acc && r < f) begin
            rc = ticks(r);
            push(r, 0, (rc - fcap) & 255, 1, tag_lo);
            last_r = r;
            fc = ticks(f);
            push(f, 1, fc, 0, tag_hi);
            fcap = fc;
        end else if (acc) begin
            fc = ticks(f);
            push(f, 1, fc, 1, "R8");
            fcap = fc;
            push(f + 1, 0, 0, 1, "R8");
            last_r = r;
        end else begin
            fc = ticks(f);
            push(f, 1, fc, 0, tag_hi);
            fcap = fc;
        end
    endtask

    task automatic seg_high(int h);
        int  a;
        bit  acc;
        a = cyc;
        sig_in = 1'b1;
        acc = !filt_m && (h >= FLEN);
        expect_high(a + 3 + FLEN, acc, a + h + 3);
        if (acc) filt_m = 1'b1;
        repeat (h) @(negedge clk);
    endtask

    task automatic seg_low(int w);
        sig_in = 1'b0;
        if (w >= FLEN) filt_m = 1'b0;
        repeat (w) @(negedge clk);
    endtask

    // Scoreboard: compare each report with the head of the expected queue.
    always @(negedge clk) begin
        if (rst_n && started) begin
            while (q_cyc.size() > 0 && q_cyc[0] < cyc) begin
                chk(1'b0, q_req[0], "report missing, cycle", cyc, q_cyc[0]);
                pop();
            end
            if (out_valid) begin
                if (q_cyc.size() == 0) begin
                    chk(1'b0, idle_req, "unexpected report, level", out_level, -1);
                end else begin
                    chk(cyc == q_cyc[0], q_req[0], "report cycle", cyc, q_cyc[0]);
                    chk(out_level == q_lvl[0][0], q_req[0], "out_level", out_level, q_lvl[0]);
                    chk(int'(out_dur) == q_dur[0], q_req[0], "out_dur", out_dur, q_dur[0]);
                    chk(mirror == q_mir[0][0], "R6", "mirror at report", mirror, q_mir[0]);
                    pop();
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "R1", "watchdog expired, cycle", cyc, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd91357));
        // R9: reset state
        repeat (4) @(negedge clk);
        chk(out_valid == 1'b0, "R9", "out_valid in reset", out_valid, 0);
        chk(mirror == 1'b0, "R9", "mirror in reset", mirror, 0);
        chk(out_dur == '0, "R9", "out_dur in reset", out_dur, 0);
        chk(out_level == 1'b0, "R9", "out_level in reset", out_level, 0);
        rst_n = 1'b1;
        @(negedge clk);
        started = 1'b1;
        en = 1'b1; last_r = cyc; fcap = 0; filt_m = 0;
        seg_low(10);

        // R1: floor of elapsed cycles by the tick divider
        tag_hi = "R1"; tag_lo = "R1";
        seg_high(FLEN + 8);  seg_low(12);
        seg_high(FLEN + 11); seg_low(12);
        seg_high(FLEN + 12); seg_low(13);

        // R8: fall and accepted rise on one edge
        seg_high(FLEN); seg_low(15);
        seg_high(FLEN); seg_low(9);

        // R5: glitches on either level
        tag_hi = "R5"; tag_lo = "R5"; idle_req = "R5";
        seg_high(20); seg_low(2); seg_high(15); seg_low(20);
        seg_high(2);  seg_low(20);
        seg_high(1);  seg_low(10);
        seg_high(FLEN - 1); seg_low(FLEN - 1); seg_high(12); seg_low(12);

        // R4: counter wrap over a long high pulse
        tag_hi = "R4"; tag_lo = "R4";
        seg_high(1100); seg_low(40);
        seg_high(10);   seg_low(20);

        // R2 / R3: random pulse trains
        tag_hi = "R2"; tag_lo = "R3";
        for (int i = 0; i < 150; i++) begin
            int h;
            int w;
            h = 1 + int'($urandom % 40);
            w = 1 + int'($urandom % 40);
            if ($urandom % 8 == 0) h = FLEN;
            seg_high(h);
            seg_low(w);
        end
        seg_low(30);

        // R7: disabled phase ignores activity
        tag_hi = "R7"; tag_lo = "R7"; idle_req = "R7";
        en = 1'b0;
        sig_in = 1'b1; repeat (30) @(negedge clk);
        chk(mirror == 1'b0, "R7", "mirror while disabled", mirror, 0);
        sig_in = 1'b0; repeat (3) @(negedge clk);
        sig_in = 1'b1; repeat (30) @(negedge clk);
        chk(out_valid == 1'b0, "R7", "out_valid while disabled", out_valid, 0);
        sig_in = 1'b0; repeat (30) @(negedge clk);
        chk(mirror == 1'b0, "R7", "mirror while disabled", mirror, 0);

        // R7: enable with the input already high
        sig_in = 1'b1; repeat (6) @(negedge clk);
        begin
            int s;
            s = cyc;
            en = 1'b1; last_r = s; fcap = 0; filt_m = 1'b1;
            expect_high(s + FLEN + 1, 1'b1, s + 23);
            repeat (20) @(negedge clk);
        end
        seg_low(30);

        // R7: disable again and restart with a low input, counting from zero
        en = 1'b0;
        repeat (10) @(negedge clk);
        en = 1'b1; last_r = cyc; fcap = 0; filt_m = 0;
        seg_low(9);
        seg_high(12); seg_low(20);

        repeat (20) @(negedge clk);
        chk(q_cyc.size() == 0, "R2", "reports still outstanding", q_cyc.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule